// File: doc/BRIEF.md
# Audio DMA Request Latch Bank

This block sits between a multi-channel audio/modem serial-link controller and a system DMA controller. It provides one request line for each sample-data channel. Channels 0 to 4 are transmit channels: front PCM, surround, center, LFE and modem out. Channels 5 and 6 are receive channels: audio in and modem in. Each channel holds one 32-bit sample word, and that word is reached through a simple register bus.

A transmit channel raises its request when the link side has consumed its word and needs a new one. A receive channel raises its request when the link side has deposited a word that must be collected. Each request is an active-low level. It stays asserted until the DMA controller moves exactly one word by accessing that channel's sample register. For a transmit channel the access is a write. For a receive channel the access is a read.

Turning off a channel's enable bit stops new requests from being raised. It does not withdraw a request that is already pending. Link events that arrive while a request is still outstanding are recorded in a sticky lost-event flag for that channel. The same happens when a link event lands in the cycle the request is being serviced.

Top module: `sdreq_bank`

## Requirements
- R1: After synchronous active-high reset, every `dma_req_n` bit is 1, the enable register reads 0, the status register reads 0 and every sample word is 0.
- R2: `dma_req_n[c]` is 0 exactly while channel c has a pending request. The request is a level: it holds for any number of cycles until it is serviced.
- R3: A one-cycle `tx_consume[i]` pulse while enable bit i is 1 drives `dma_req_n[i]` low from the next clock edge. Here i is 0 to 4.
- R4: A one-cycle `rx_valid[j]` pulse while enable bit 5+j is 1 captures `rx_sample[32*j +: 32]` into channel 5+j. It also drives `dma_req_n[5+j]` low from the next edge.
- R5: A link strobe on a channel whose enable bit is 0 has no effect: no request is raised, no flag is set and the receive word is not captured.
- R6: A write to address 0x10+4*i clears transmit channel i's request and stores the word, which appears on `tx_sample[32*i +: 32]`. A read of that address returns the word and leaves the request pending.
- R7: A read of address 0x24 (channel 5) or 0x28 (channel 6) returns the captured word in the same cycle and clears that request. A write to those addresses is ignored.
- R8: Clearing a channel's enable bit leaves its pending request asserted. The request can still be cleared by the matching access.
- R9: A link event on an enabled channel whose request is still pending sets that channel's sticky flag, which is status bit 8+c. The request stays pending, and a receive word already captured is kept.
- R10: When an enabled link event and the servicing access fall in the same cycle, the access wins. The request clears and flag 8+c is set.
- R11: Register map, in 32-bit words:
  - Address 0x00 is the enable register. Bits 6:0 are read/write; the other bits read 0.
  - Address 0x04 is the read-only status register. Bits 6:0 hold the pending requests and bits 14:8 hold the flags. Writes to it are ignored.
  - Addresses 0x10 to 0x28 are the sample registers, one per channel at a stride of 4 bytes.
  - Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_consume | input | 5 | Link has consumed the transmit word, one bit per transmit channel |
| rx_valid | input | 2 | Link has deposited a receive word, one bit per receive channel |
| rx_sample | input | 64 | Receive words from the link, 32 bits per receive channel |
| tx_sample | output | 160 | Transmit words toward the link, 32 bits per transmit channel |
| dma_req_n | output | 7 | Active-low level DMA requests, one per channel |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |

## Verification
The bench builds the block with its default shape: five transmit channels, two receive channels and 32-bit words. With that shape every channel and every register address can be swept one by one in each scenario. Each channel is taken through the following sequences:
- raise, hold, then service the request;
- a strobe while disabled;
- enable removed while a request is pending;
- a repeated event while pending;
- an event and its servicing access in the same cycle.

In every sequence the request vector and the status register are compared against values the bench computes from the channel index. Wrong-direction accesses are also covered: reads of transmit words and writes to receive words. So are writes to the read-only status register and reads of unmapped addresses.

// File: rtl/sdreq_pkg.sv
package sdreq_pkg;

    localparam int ADDR_W   = 8;
    localparam int FLAG_LSB = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h04;
    localparam logic [ADDR_W-1:0] A_SAMPLE0 = 8'h10;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_ENABLE,
        REG_STATUS,
        REG_SAMPLE
    } reg_kind_e;

    // Byte address of the sample register for channel c.
    function automatic int sample_addr(input int c);
        return int'(A_SAMPLE0) + 4 * c;
    endfunction

endpackage

// File: rtl/sdreq_regdec.sv
module sdreq_regdec
    import sdreq_pkg::*;
#(
    parameter int N_CH = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [N_CH-1:0]   ch_sel
);

    always_comb begin
        kind   = REG_NONE;
        ch_sel = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == A_ENABLE) begin
                kind = REG_ENABLE;
            end else if (addr == A_STATUS) begin
                kind = REG_STATUS;
            end else begin
                for (int c = 0; c < N_CH; c++) begin
                    if (int'(addr) == sample_addr(c)) begin
                        kind      = REG_SAMPLE;
                        ch_sel[c] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sdreq_chan.sv
module sdreq_chan #(
    parameter int DATA_W = 32,
    parameter bit IS_RX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              link_evt,
    input  logic              acc,
    input  logic [DATA_W-1:0] din,
    output logic              pend,
    output logic              flag,
    output logic [DATA_W-1:0] data
);

    logic              pend_q;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;
    logic              evt_on;
    logic              take;
    logic              load;

    assign evt_on = link_evt & en;
    assign take   = evt_on & ~pend_q & ~acc;

    generate
        if (IS_RX) begin : g_rx
            assign load = take;   // word arrives from the link
        end else begin : g_tx
            assign load = acc;    // word arrives from the bus
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flag_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (acc) begin
                pend_q <= 1'b0;
            end else if (take) begin
                pend_q <= 1'b1;
            end
            if (evt_on && (pend_q || acc)) begin
                flag_q <= 1'b1;
            end
            if (load) begin
                data_q <= din;
            end
        end
    end

    assign pend = pend_q;
    assign flag = flag_q;
    assign data = data_q;

    // R6 / R7: the servicing access always clears the latch
    a_r6_access_clears: assert property (@(posedge clk) disable iff (rst)
        acc |=> !pend_q);

    // R3 / R4: an enabled event on an idle channel raises the request
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        (link_evt && en && !pend_q && !acc) |=> pend_q);

    // R5: no request appears without an enabled event
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !(link_evt && en)) |=> !pend_q);

    // R8: only the access withdraws a pending request
    a_r8_hold_until_access: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !acc) |=> pend_q);

    // R9 / R10: a lost event sets the sticky flag
    a_r9_lost_flagged: assert property (@(posedge clk) disable iff (rst)
        (link_evt && en && (pend_q || acc)) |=> flag_q);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> flag_q);

    // R9: a receive word is not replaced while it is still pending
    a_r9_rx_word_kept: assert property (@(posedge clk) disable iff (rst)
        (IS_RX && pend_q) |=> $stable(data_q));

endmodule

// File: rtl/sdreq_bank.sv
module sdreq_bank
    import sdreq_pkg::*;
#(
    parameter int N_TX   = 5,
    parameter int N_RX   = 2,
    parameter int DATA_W = 32,
    localparam int N_CH  = N_TX + N_RX
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_TX-1:0]        tx_consume,
    input  logic [N_RX-1:0]        rx_valid,
    input  logic [N_RX*DATA_W-1:0] rx_sample,
    output logic [N_TX*DATA_W-1:0] tx_sample,
    output logic [N_CH-1:0]        dma_req_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata
);

    reg_kind_e         kind;
    logic [N_CH-1:0]   ch_sel;
    logic [N_CH-1:0]   en_q;
    logic [N_CH-1:0]   pend;
    logic [N_CH-1:0]   flag;
    logic [DATA_W-1:0] ch_data [N_CH];
    logic              wr_stb;
    logic              rd_stb;

    assign wr_stb = bus_sel & bus_wr;
    assign rd_stb = bus_sel & ~bus_wr;

    sdreq_regdec #(.N_CH(N_CH)) u_dec (
        .addr   (bus_addr),
        .kind   (kind),
        .ch_sel (ch_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_stb && kind == REG_ENABLE) begin
            en_q <= bus_wdata[N_CH-1:0];
        end
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            if (c < N_TX) begin : g_tx
                sdreq_chan #(.DATA_W(DATA_W), .IS_RX(1'b0)) u_chan (
                    .clk      (clk),
                    .rst      (rst),
                    .en       (en_q[c]),
                    .link_evt (tx_consume[c]),
                    .acc      (wr_stb & ch_sel[c]),
                    .din      (bus_wdata),
                    .pend     (pend[c]),
                    .flag     (flag[c]),
                    .data     (ch_data[c])
                );
                assign tx_sample[c*DATA_W +: DATA_W] = ch_data[c];
            end else begin : g_rx
                sdreq_chan #(.DATA_W(DATA_W), .IS_RX(1'b1)) u_chan (
                    .clk      (clk),
                    .rst      (rst),
                    .en       (en_q[c]),
                    .link_evt (rx_valid[c-N_TX]),
                    .acc      (rd_stb & ch_sel[c]),
                    .din      (rx_sample[(c-N_TX)*DATA_W +: DATA_W]),
                    .pend     (pend[c]),
                    .flag     (flag[c]),
                    .data     (ch_data[c])
                );
            end
        end
    endgenerate

    assign dma_req_n = ~pend;

    always_comb begin
        bus_rdata = '0;
        case (kind)
            REG_ENABLE: bus_rdata[N_CH-1:0] = en_q;
            REG_STATUS: begin
                bus_rdata[N_CH-1:0]         = pend;
                bus_rdata[FLAG_LSB +: N_CH] = flag;
            end
            REG_SAMPLE: begin
                for (int c = 0; c < N_CH; c++) begin
                    if (ch_sel[c]) bus_rdata = ch_data[c];
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    // R11: at most one sample register is selected by an address
    a_r11_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

    // R11: the enable register takes the written bits
    a_r11_enable_write: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && kind == REG_ENABLE) |=> en_q == $past(bus_wdata[N_CH-1:0]));

    // R11: only a write to the enable address changes the enables
    a_r11_enable_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && kind == REG_ENABLE) |=> $stable(en_q));

endmodule

// File: tb/sim_sdreq_bank.sv
module sim_sdreq_bank;

    localparam int NT = 5;
    localparam int NR = 2;
    localparam int NC = 7;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NT-1:0]   tx_consume = '0;
    logic [NR-1:0]   rx_valid = '0;
    logic [NR*DW-1:0] rx_sample = '0;
    logic [NT*DW-1:0] tx_sample;
    logic [NC-1:0]   dma_req_n;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdreq_bank u0 (
        .clk        (clk),
        .rst        (rst),
        .tx_consume (tx_consume),
        .rx_valid   (rx_valid),
        .rx_sample  (rx_sample),
        .tx_sample  (tx_sample),
        .dma_req_n  (dma_req_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    function automatic logic [7:0] saddr(input int c);
        return 8'(16 + 4 * c);
    endfunction

    function automatic logic [31:0] pat(input int c, input int k);
        return 32'hC0DE_0000 + 32'(c) * 32'h0001_1111 + 32'(k) * 32'h0100_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [NT-1:0] t, input logic [NR-1:0] r);
        tx_consume = t; rx_valid = r;
        @(negedge clk);
        tx_consume = '0; rx_valid = '0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_all;
        logic [31:0] d;
        for (int i = 0; i < NT; i++) bwrite(saddr(i), pat(i, 9));
        for (int j = 0; j < NR; j++) bread(saddr(NT + j), d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_flags;
        @(negedge clk);
        do_reset;

        // R1 reset state
        chk("R1 req_n", 32'(dma_req_n), 32'h7F);
        bread(8'h00, rd); chk("R1 enable", rd, 0);
        bread(8'h04, rd); chk("R1 status", rd, 0);
        for (int i = 0; i < NT; i++) chk("R1 tx word", tx_sample[i*DW +: DW], 0);

        // R11 register map
        bwrite(8'h00, 32'hFFFF_FFFF);
        bread(8'h00, rd); chk("R11 enable readback", rd, 32'h7F);
        bwrite(8'h04, 32'hFFFF_FFFF);
        bread(8'h04, rd); chk("R11 status read-only", rd, 0);
        bread(8'h08, rd); chk("R11 unmapped", rd, 0);
        bread(8'h2C, rd); chk("R11 unmapped past last", rd, 0);
        bread(8'h11, rd); chk("R11 unaligned", rd, 0);

        // R3, R2, R6: transmit raise, hold, service
        for (int i = 0; i < NT; i++) begin
            pulse(NT'(1 << i), '0);
            chk("R3 tx request", 32'(dma_req_n), 32'(7'h7F & ~(7'd1 << i)));
            repeat (3) @(negedge clk);
            chk("R2 level held", 32'(dma_req_n), 32'(7'h7F & ~(7'd1 << i)));
            bread(8'h04, rd); chk("R2 status pending", rd, 32'(1 << i));
            bread(saddr(i), rd);
            chk("R6 read keeps request", 32'(dma_req_n), 32'(7'h7F & ~(7'd1 << i)));
            bwrite(saddr(i), pat(i, 1));
            chk("R6 write clears", 32'(dma_req_n), 32'h7F);
            chk("R6 tx word out", tx_sample[i*DW +: DW], pat(i, 1));
            bread(saddr(i), rd); chk("R6 tx word readback", rd, pat(i, 1));
        end

        // R4, R7: receive raise, wrong-direction write, service
        for (int j = 0; j < NR; j++) begin
            rx_sample[j*DW +: DW] = pat(NT + j, 1);
            pulse('0, NR'(1 << j));
            chk("R4 rx request", 32'(dma_req_n), 32'(7'h7F & ~(7'd1 << (NT + j))));
            bwrite(saddr(NT + j), 32'hDEAD_BEEF);
            chk("R7 write ignored req", 32'(dma_req_n), 32'(7'h7F & ~(7'd1 << (NT + j))));
            bread(saddr(NT + j), rd);
            chk("R7 rx word", rd, pat(NT + j, 1));
            chk("R7 read clears", 32'(dma_req_n), 32'h7F);
        end

        // R5: strobes while disabled
        bwrite(8'h00, 0);
        for (int j = 0; j < NR; j++) rx_sample[j*DW +: DW] = pat(NT + j, 2);
        pulse('1, '1);
        chk("R5 no request", 32'(dma_req_n), 32'h7F);
        bread(8'h04, rd); chk("R5 no flag", rd, 0);
        for (int j = 0; j < NR; j++) begin
            bread(saddr(NT + j), rd); chk("R5 rx not captured", rd, pat(NT + j, 1));
        end

        // R8: disabling keeps pending requests
        bwrite(8'h00, 32'h7F);
        for (int j = 0; j < NR; j++) rx_sample[j*DW +: DW] = pat(NT + j, 3);
        pulse('1, '1);
        chk("R8 all pending", 32'(dma_req_n), 0);
        bwrite(8'h00, 0);
        chk("R8 disable keeps req", 32'(dma_req_n), 0);
        bread(8'h04, rd); chk("R8 status pending", rd, 32'h7F);
        clear_all;
        chk("R8 cleared by access", 32'(dma_req_n), 32'h7F);

        // R9: repeated event while pending
        bwrite(8'h00, 32'h7F);
        for (int c = 0; c < NC; c++) begin
            if (c < NT) begin
                pulse(NT'(1 << c), '0);
                pulse(NT'(1 << c), '0);
            end else begin
                rx_sample[(c-NT)*DW +: DW] = pat(c, 4);
                pulse('0, NR'(1 << (c - NT)));
                rx_sample[(c-NT)*DW +: DW] = pat(c, 5);
                pulse('0, NR'(1 << (c - NT)));
            end
            exp_flags = ((32'd1 << (c + 1)) - 1) << 8;
            bread(8'h04, rd); chk("R9 flag and pending", rd, exp_flags | 32'(1 << c));
            if (c < NT) begin
                bwrite(saddr(c), pat(c, 6));
            end else begin
                bread(saddr(c), rd); chk("R9 first rx word kept", rd, pat(c, 4));
            end
            chk("R9 cleared", 32'(dma_req_n), 32'h7F);
        end

        // R1: reset clears sticky flags and enables
        do_reset;
        bread(8'h04, rd); chk("R1 flags cleared", rd, 0);
        bread(8'h00, rd); chk("R1 enables cleared", rd, 0);

        // R10: event and access in the same cycle
        bwrite(8'h00, 32'h7F);
        for (int c = 0; c < NC; c++) begin
            bus_sel = 1'b1;
            bus_addr = saddr(c);
            if (c < NT) begin
                bus_wr = 1'b1; bus_wdata = pat(c, 7);
                tx_consume = NT'(1 << c);
            end else begin
                bus_wr = 1'b0;
                rx_valid = NR'(1 << (c - NT));
            end
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; tx_consume = '0; rx_valid = '0;
            chk("R10 access wins", 32'(dma_req_n), 32'h7F);
            exp_flags = ((32'd1 << (c + 1)) - 1) << 8;
            bread(8'h04, rd); chk("R10 lost flagged", rd, exp_flags);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule